// File: doc/BRIEF.md
# Three-wire serial EEPROM command sequencer

This block is the host side of a three-wire serial EEPROM link. It takes one request at a time (a command, an address, write data, the word size and a burst length), and turns it into chip-select, serial-clock and data-out activity on the pins. It also samples the device's data line. Read words come back on a response strobe. Every request ends with a single completion pulse. That pulse carries a timeout flag for programming commands whose ready indication never arrived.

The serial clock is derived from the system clock. The high time, the low time, the minimum chip-select low gap and the status-valid delay are all given in nanoseconds and converted to cycle counts from the clock frequency in MHz. The block sequences programming commands on its own. It first sends an enable frame. It then sends the command, drops chip-select and waits out the gap. Next it raises chip-select with the data line held low and no clock edges, and watches for the device to report ready. A disable frame can optionally follow.

Top module: `mw_eeprom_seq`

## Requirements
- R1: After reset, `cs`, `sk`, `di`, `done`, `timeout` and `rsp_valid` are low and `req_ready` is high.
- R2: `sk` rises only while `cs` is high. Each high phase and each low phase of `sk` lasts at least ceil(ns × CLK_MHZ / 1000) clocks for the configured high and low times (13 clocks each with the defaults).
- R3: A frame is shifted out MSB first and sampled by the device on each `sk` rise. It is a 1, then a 2-bit opcode, then the address field, then the data field for the two write commands. `di` changes only while `sk` is low.
- R4: Request codes on `req_op` are: 0 read, 1 write, 2 erase, 3 write-all, 4 erase-all, 5 enable, 6 disable. The device opcodes are: read 10, write 01, erase 11. Every other command uses opcode 00 with the top two address bits set to 11 for enable, 00 for disable, 01 for write-all and 10 for erase-all, and the remaining address bits zero.
- R5: Codes 1 to 4 are each preceded by an enable frame. If `req_auto_dis` is set, a disable frame follows once the device reports ready.
- R6: For a read, the first bit after the address is a dummy and is discarded. Then `max(req_len,1)` words are returned MSB first on `rsp_data`/`rsp_valid`, from consecutive addresses that wrap at the top of the address space, all within one `cs`-high period.
- R7: `cs` falls only while `sk` is low, directly after the last frame bit. Between any two `cs`-high periods, `cs` stays low for at least the configured gap (13 clocks with the defaults).
- R8: After a programming frame, `cs` is raised again with `di` low and no `sk` edge until `sdo` reads 1. `cs` then drops, and `done` pulses with `timeout` low.
- R9: If `sdo` has not read 1 within POLL_TO_CYC clocks of the `cs` fall that ends a programming frame, `done` pulses with `timeout` high and no disable frame is sent.
- R10: With `req_x16` low, the address field is 11 bits and the data field is 8 bits, and `rsp_data[15:8]` is zero. With `req_x16` high, the address field is 10 bits and the data field is 16 bits.
- R11: While a request is in progress, `req_ready` is low and `req_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_ready | output | 1 | Sequencer idle |
| req_op | input | 3 | Request code (see R4) |
| req_x16 | input | 1 | 1: 16-bit words, 0: 8-bit words |
| req_addr | input | 11 | Word address |
| req_wdata | input | 16 | Write data (low byte used in 8-bit mode) |
| req_len | input | LEN_W | Read burst length in words, 0 treated as 1 |
| req_auto_dis | input | 1 | Send a disable frame after a programming command |
| rsp_valid | output | 1 | One-cycle strobe for a read word |
| rsp_data | output | 16 | Read word |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Valid with `done`: ready was never seen |
| cs | output | 1 | Device chip select |
| sk | output | 1 | Serial clock |
| di | output | 1 | Serial data to the device |
| sdo | input | 1 | Serial data and ready/busy status from the device |

## Verification
A behavioural device model on the bench captures every frame bit at `sk` rises. It serves reads from an address-derived pattern and holds `sdo` low for a set time after each programming frame. The table covers every request code in both word sizes. Single-word reads test the dummy-bit discard. Bursts that cross the top address test wrap-around and the absence of a second dummy. Zero length tests the one-word floor. Writes with and without the trailing disable tell R5's optional frame apart from the fixed enable frame. Directed cases hold the device busy past the poll limit to show the timeout path, and they assert a request mid-operation to show it is ignored.

// File: rtl/mw_eeprom_seq.sv
module mw_eeprom_seq #(
  parameter int CLK_MHZ     = 50,
  parameter int SK_HI_NS    = 250,
  parameter int SK_LO_NS    = 250,
  parameter int CS_LO_NS    = 250,
  parameter int SV_NS       = 500,
  parameter int POLL_TO_CYC = 600000,
  parameter int LEN_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic             req_x16,
  input  logic [10:0]      req_addr,
  input  logic [15:0]      req_wdata,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_auto_dis,
  output logic             rsp_valid,
  output logic [15:0]      rsp_data,
  output logic             done,
  output logic             timeout,
  output logic             cs,
  output logic             sk,
  output logic             di,
  input  logic             sdo
);
  localparam int SKHI_C = ((SK_HI_NS * CLK_MHZ + 999) / 1000) < 1 ? 1 : (SK_HI_NS * CLK_MHZ + 999) / 1000;
  localparam int SKLO_C = ((SK_LO_NS * CLK_MHZ + 999) / 1000) < 1 ? 1 : (SK_LO_NS * CLK_MHZ + 999) / 1000;
  localparam int CSLO_C = ((CS_LO_NS * CLK_MHZ + 999) / 1000) < 1 ? 1 : (CS_LO_NS * CLK_MHZ + 999) / 1000;
  localparam int SV_C   = ((SV_NS * CLK_MHZ + 999) / 1000) < 1 ? 1 : (SV_NS * CLK_MHZ + 999) / 1000;
  localparam int CW     = 16;
  localparam int TOW    = $clog2(POLL_TO_CYC + 1);
  localparam logic [1:0] STG_EN = 2'd0, STG_MAIN = 2'd1, STG_DIS = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_LO, S_HI, S_GAP, S_SV, S_POLL} st_t;

  st_t              st;
  logic [1:0]       stage;
  logic [CW-1:0]    cnt, lim;
  logic [2:0]       op_q;
  logic             x16_q, adis_q, poll_pend, abort, rd_ph, dummy;
  logic [10:0]      addr_q;
  logic [15:0]      wd_q, sh;
  logic [28:0]      fr, frm;
  logic [4:0]       bitn, flen, dbits;
  logic [LEN_W-1:0] wleft;
  logic [TOW-1:0]   to_cnt;
  logic [1:0]       opc, code;
  logic             use_code, hasd;
  logic [9:0]       af16;
  logic [10:0]      af8;
  logic             polling;

  wire        prog     = (op_q != 3'd0) && (op_q < 3'd5);
  wire        req_prog = (req_op != 3'd0) && (req_op < 3'd5);
  wire        ph_end   = (cnt == lim);
  wire [15:0] nxt      = {sh[14:0], sdo};
  wire [4:0]  dw       = x16_q ? 5'd16 : 5'd8;

  assign req_ready = (st == S_IDLE);
  assign polling   = (st == S_POLL);

  always_comb begin
    case (st)
      S_LO:    lim = CW'(SKLO_C - 1);
      S_HI:    lim = CW'(SKHI_C - 1);
      S_GAP:   lim = CW'(CSLO_C - 1);
      S_SV:    lim = CW'(SV_C - 1);
      default: lim = '0;
    endcase
  end

  always_comb begin
    opc = 2'b00; code = 2'b00; use_code = 1'b1; hasd = 1'b0;
    if (stage == STG_EN)       code = 2'b11;
    else if (stage == STG_MAIN) begin
      case (op_q)
        3'd0: begin opc = 2'b10; use_code = 1'b0; end
        3'd1: begin opc = 2'b01; use_code = 1'b0; hasd = 1'b1; end
        3'd2: begin opc = 2'b11; use_code = 1'b0; end
        3'd3: begin code = 2'b01; hasd = 1'b1; end
        3'd4: code = 2'b10;
        3'd5: code = 2'b11;
        default: code = 2'b00;
      endcase
    end
    af16 = use_code ? {code, 8'b0} : addr_q[9:0];
    af8  = use_code ? {code, 9'b0} : addr_q;
    frm  = x16_q ? {1'b1, opc, af16, wd_q} : {1'b1, opc, af8, wd_q[7:0], 7'b0};
    flen = (x16_q ? 5'd13 : 5'd14) + (hasd ? dw : 5'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; stage <= STG_MAIN; cnt <= '0;
      op_q <= '0; x16_q <= 1'b0; adis_q <= 1'b0; addr_q <= '0; wd_q <= '0; wleft <= '0;
      poll_pend <= 1'b0; abort <= 1'b0; rd_ph <= 1'b0; dummy <= 1'b0;
      sh <= '0; fr <= '0; bitn <= '0; dbits <= '0; to_cnt <= '0;
      cs <= 1'b0; sk <= 1'b0; di <= 1'b0;
      rsp_valid <= 1'b0; rsp_data <= '0; done <= 1'b0; timeout <= 1'b0;
    end else begin
      rsp_valid <= 1'b0; done <= 1'b0; timeout <= 1'b0;
      cnt <= ph_end ? '0 : cnt + 1'b1;
      if (poll_pend) to_cnt <= to_cnt + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= req_op; x16_q <= req_x16; addr_q <= req_addr; wd_q <= req_wdata;
          adis_q <= req_auto_dis; abort <= 1'b0;
          wleft <= (req_len == '0) ? LEN_W'(1) : req_len;
          stage <= req_prog ? STG_EN : STG_MAIN;
          st <= S_LOAD;
        end
        S_LOAD: begin
          fr <= frm; bitn <= flen; cs <= 1'b1; di <= frm[28]; rd_ph <= 1'b0;
          cnt <= '0; st <= S_LO;
        end
        S_LO: if (ph_end) begin
          if (rd_ph) begin
            if (dummy) dummy <= 1'b0;
            else begin
              sh <= nxt;
              if (dbits == 5'd1) begin
                rsp_valid <= 1'b1;
                rsp_data  <= x16_q ? nxt : {8'h00, nxt[7:0]};
                dbits <= dw;
                wleft <= wleft - 1'b1;
              end else dbits <= dbits - 1'b1;
            end
            if (!dummy && dbits == 5'd1 && wleft == LEN_W'(1)) begin
              cs <= 1'b0; st <= S_GAP;
            end else begin
              sk <= 1'b1; st <= S_HI;
            end
          end else begin
            sk <= 1'b1; st <= S_HI;
          end
        end
        S_HI: if (ph_end) begin
          sk <= 1'b0;
          if (rd_ph) st <= S_LO;
          else if (bitn == 5'd1) begin
            di <= 1'b0;
            if (stage == STG_MAIN && op_q == 3'd0) begin
              rd_ph <= 1'b1; dummy <= 1'b1; dbits <= dw; st <= S_LO;
            end else begin
              cs <= 1'b0; st <= S_GAP; to_cnt <= '0;
              poll_pend <= (stage == STG_MAIN) && prog;
            end
          end else begin
            bitn <= bitn - 1'b1; fr <= {fr[27:0], 1'b0}; di <= fr[27]; st <= S_LO;
          end
        end
        S_GAP: if (ph_end) begin
          if (poll_pend) begin
            cs <= 1'b1; st <= S_SV;
          end else if (!abort && stage == STG_EN) begin
            stage <= STG_MAIN; st <= S_LOAD;
          end else if (!abort && stage == STG_MAIN && prog && adis_q) begin
            stage <= STG_DIS; st <= S_LOAD;
          end else begin
            done <= 1'b1; timeout <= abort; st <= S_IDLE;
          end
        end
        S_SV: if (ph_end) st <= S_POLL;
        S_POLL: begin
          if (sdo) begin
            cs <= 1'b0; poll_pend <= 1'b0; st <= S_GAP;
          end else if (to_cnt >= TOW'(POLL_TO_CYC - 1)) begin
            cs <= 1'b0; poll_pend <= 1'b0; abort <= 1'b1; st <= S_GAP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_seq_chk.sv
module mw_eeprom_seq_chk #(
  parameter int SKHI_C = 1,
  parameter int SKLO_C = 1,
  parameter int CSLO_C = 1
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sk,
  input logic di,
  input logic done,
  input logic timeout,
  input logic req_ready,
  input logic polling
);
  logic [15:0] hi_run, lo_run, cs_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0; lo_run <= 16'hFFFF; cs_lo <= 16'hFFFF;
    end else begin
      hi_run <= sk ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
      lo_run <= !sk ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1) : '0;
      cs_lo  <= !cs ? ((cs_lo == 16'hFFFF) ? cs_lo : cs_lo + 1'b1) : '0;
    end
  end

  a_r2_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n) sk |-> cs);
  a_r2_sk_high_min: assert property (@(posedge clk) disable iff (!rst_n) $fell(sk) |-> hi_run >= 16'(SKHI_C));
  a_r2_sk_low_min:  assert property (@(posedge clk) disable iff (!rst_n) $rose(sk) |-> lo_run >= 16'(SKLO_C));
  a_r3_di_hold:     assert property (@(posedge clk) disable iff (!rst_n) (sk && $past(sk)) |-> $stable(di));
  a_r7_cs_fall_lo:  assert property (@(posedge clk) disable iff (!rst_n) $fell(cs) |-> !sk);
  a_r7_cs_gap_min:  assert property (@(posedge clk) disable iff (!rst_n) $rose(cs) |-> cs_lo >= 16'(CSLO_C));
  a_r8_poll_quiet:  assert property (@(posedge clk) disable iff (!rst_n) polling |-> (cs && !sk && !di));
  a_r9_to_with_done: assert property (@(posedge clk) disable iff (!rst_n) timeout |-> done);
  a_r11_idle_no_cs: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !cs);
endmodule

bind mw_eeprom_seq mw_eeprom_seq_chk #(.SKHI_C(SKHI_C), .SKLO_C(SKLO_C), .CSLO_C(CSLO_C)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .done(done),
  .timeout(timeout), .req_ready(req_ready), .polling(polling)
);

// File: tb/mw_eeprom_seq_tb.sv
module mw_eeprom_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 11;
  localparam int PH    = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_x16 = 1'b1, req_auto_dis = 1'b0;
  logic [2:0] req_op = '0;
  logic [10:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0] req_len = '0;
  logic req_ready, rsp_valid, done, timeout, cs, sk, di;
  logic [15:0] rsp_data;
  logic sdo = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mw_eeprom_seq #(.POLL_TO_CYC(3000)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_x16(req_x16), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_len(req_len), .req_auto_dis(req_auto_dis), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .done(done), .timeout(timeout), .cs(cs), .sk(sk),
    .di(di), .sdo(sdo)
  );

  // op, x16, addr, wdata, len, auto-disable
  localparam logic [47:0] VEC [NV] = '{
    48'h0_1_005_0000_01_0, 48'h0_1_3FE_0000_03_0, 48'h1_1_123_A5C3_00_1,
    48'h2_1_2AA_0000_00_0, 48'h3_1_000_0F0F_00_1, 48'h4_1_000_0000_00_0,
    48'h5_1_000_0000_00_0, 48'h6_0_000_0000_00_0, 48'h0_0_7FF_0000_02_0,
    48'h1_0_456_003C_00_1, 48'h0_1_0AB_0000_00_0
  };

  int nchk = 0, nerr = 0;
  bit cur_x16 = 1'b1;
  int busy_len = 300, busy = 0;
  logic sk_p = 0, cs_p = 0, sdo_m = 0;
  bit reading = 0, di_hi = 0, started = 0, done_seen = 0, to_seen = 0;
  longint rx = 0;
  int rxn = 0, raddr = 0, bidx = 0, hi = 0, lo = 0, cl = 0;
  int min_hi = 1000000, min_lo = 1000000, min_cl = 1000000;
  int n_sess = 0, npoll = 0, n_rsp = 0, done_cnt = 0;
  int s_len [8];
  longint s_bits [8];
  int rsp_w [8];
  int e_len [8];
  longint e_bits [8];
  int ne = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mdat(input int a, input bit x16);
    if (x16) return ((a * 257) ^ 'h5AC3) & 'hFFFF;
    return ((a * 7) ^ 'h96) & 'hFF;
  endfunction

  // device model and monitors
  always @(negedge clk) begin
    if (!rst_n) begin
      sk_p = 0; cs_p = 0; busy = 0; reading = 0; sdo = 1'b0;
    end else begin
      automatic bit skr = sk && !sk_p;
      automatic int aw = cur_x16 ? 10 : 11;
      automatic int dwm = cur_x16 ? 16 : 8;
      automatic int mask = (1 << aw) - 1;
      if (cs && !cs_p) begin
        rx = 0; rxn = 0; reading = 0; di_hi = 0; lo = 0;
        if (started && cl < min_cl) min_cl = cl;
        started = 1;
      end
      if (!cs) cl++; else cl = 0;
      if (cs && di) di_hi = 1;
      if (cs && skr) begin
        if (lo < min_lo) min_lo = lo;
        lo = 0;
        if (reading) begin
          automatic int w = mdat(raddr, cur_x16);
          sdo_m = ((w >> bidx) & 1) != 0;
          if (bidx == 0) begin bidx = dwm - 1; raddr = (raddr + 1) & mask; end
          else bidx--;
        end else begin
          rx = (rx << 1) | longint'(di);
          rxn++;
          if (rxn == 3 + aw && ((rx >> aw) & 3) == 2) begin
            reading = 1; raddr = int'(rx & longint'(mask)); bidx = dwm - 1; sdo_m = 1'b0;
          end
        end
      end
      if (cs && !sk) lo++;
      if (sk) hi++;
      else begin
        if (hi > 0 && hi < min_hi) min_hi = hi;
        hi = 0;
      end
      if (!cs && cs_p) begin
        if (rxn > 0) begin
          if (n_sess < 8) begin s_len[n_sess] = rxn; s_bits[n_sess] = rx; end
          n_sess++;
          if (!reading) begin
            automatic int opc = int'((rx >> (rxn - 3)) & 3);
            automatic int cd = int'((rx >> (rxn - 5)) & 3);
            if (opc == 1 || opc == 3 || (opc == 0 && (cd == 1 || cd == 2))) busy = busy_len;
          end
        end else begin
          npoll++;
          chk(!di_hi, "R8 di low during status poll", longint'(di_hi), 0);
        end
        reading = 0;
      end
      if (busy > 0) busy--;
      sdo = reading ? sdo_m : (cs && busy == 0);
      if (rsp_valid) begin
        if (n_rsp < 8) rsp_w[n_rsp] = int'(rsp_data);
        n_rsp++;
      end
      if (done) begin done_seen = 1; to_seen = timeout; done_cnt++; end
      sk_p = sk; cs_p = cs;
    end
  end

  task automatic add_exp(input int opc, input longint af, input int aw, input bit hd, input longint d, input int dwm);
    e_bits[ne] = (longint'(4 | opc) << aw) | af;
    if (hd) e_bits[ne] = (e_bits[ne] << dwm) | d;
    e_len[ne] = 3 + aw + (hd ? dwm : 0);
    ne++;
  endtask

  task automatic build_exp(input int op, input bit x16, input int addr, input int wd, input bit adis);
    automatic int aw = x16 ? 10 : 11;
    automatic int dwm = x16 ? 16 : 8;
    automatic longint a = longint'(addr & ((1 << aw) - 1));
    automatic longint d = longint'(wd & ((1 << dwm) - 1));
    automatic bit prog = (op >= 1 && op <= 4);
    ne = 0;
    if (prog) add_exp(0, longint'(3) << (aw - 2), aw, 0, 0, dwm);
    case (op)
      0: add_exp(2, a, aw, 0, 0, dwm);
      1: add_exp(1, a, aw, 1, d, dwm);
      2: add_exp(3, a, aw, 0, 0, dwm);
      3: add_exp(0, longint'(1) << (aw - 2), aw, 1, d, dwm);
      4: add_exp(0, longint'(2) << (aw - 2), aw, 0, 0, dwm);
      5: add_exp(0, longint'(3) << (aw - 2), aw, 0, 0, dwm);
      default: add_exp(0, 0, aw, 0, 0, dwm);
    endcase
    if (prog && adis) add_exp(0, 0, aw, 0, 0, dwm);
  endtask

  task automatic clear_obs();
    n_sess = 0; npoll = 0; n_rsp = 0; done_seen = 0; to_seen = 0; done_cnt = 0;
  endtask

  task automatic send(input int op, input bit x16, input int addr, input int wd, input int len, input bit adis);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_x16 = x16;
    req_op = 3'(op); req_x16 = x16; req_addr = 11'(addr); req_wdata = 16'(wd);
    req_len = 8'(len); req_auto_dis = adis; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    automatic int g = 0;
    while (!done_seen && g < 40000) begin @(negedge clk); g++; end
    chk(done_seen, "R8 request completes with done", longint'(done_seen), 1);
  endtask

  task automatic check_frames(input string tag);
    chk(n_sess == ne, {tag, " frame count (R5)"}, n_sess, ne);
    for (int i = 0; i < ne && i < n_sess && i < 8; i++) begin
      chk(s_len[i] == e_len[i], {tag, " frame length (R3 R10)"}, s_len[i], e_len[i]);
      chk(s_bits[i] == e_bits[i], {tag, " frame bits (R3 R4)"}, s_bits[i], e_bits[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs == 1'b0 && sk == 1'b0 && di == 1'b0, "R1 pins low after reset", {cs, sk, di}, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(done == 1'b0 && timeout == 1'b0 && rsp_valid == 1'b0, "R1 strobes low after reset", {done, timeout, rsp_valid}, 0);
    repeat (20) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      automatic int op = int'(VEC[v][47:44]);
      automatic bit x16 = VEC[v][40];
      automatic int addr = int'(VEC[v][39:28]);
      automatic int wd = int'(VEC[v][27:12]);
      automatic int len = int'(VEC[v][11:4]);
      automatic bit adis = VEC[v][0];
      automatic bit prog = (op >= 1 && op <= 4);
      automatic string tag = $sformatf("vec%0d", v);
      clear_obs();
      send(op, x16, addr, wd, len, adis);
      wait_done();
      build_exp(op, x16, addr, wd, adis);
      check_frames(tag);
      chk(to_seen == 0, {tag, " no timeout (R8)"}, to_seen, 0);
      chk(npoll == (prog ? 1 : 0), {tag, " status poll count (R8)"}, npoll, prog ? 1 : 0);
      if (op == 0) begin
        automatic int words = (len == 0) ? 1 : len;
        automatic int mask = x16 ? 'h3FF : 'h7FF;
        chk(n_rsp == words, {tag, " read word count (R6)"}, n_rsp, words);
        for (int k = 0; k < words && k < n_rsp && k < 8; k++) begin
          automatic int e = mdat((addr + k) & mask, x16);
          chk(rsp_w[k] == e, {tag, x16 ? " read data (R6)" : " read data 8-bit (R6 R10)"}, rsp_w[k], e);
        end
      end else chk(n_rsp == 0, {tag, " no read words (R6)"}, n_rsp, 0);
      repeat (5) @(negedge clk);
    end

    // R11: request while busy is ignored
    clear_obs();
    send(1, 1'b1, 'h0F0, 'h1234, 0, 1'b0);
    repeat (200) @(negedge clk);
    req_op = 3'd2; req_addr = 11'h055; req_valid = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R11 not ready while busy", req_ready, 0);
    repeat (40) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    repeat (300) @(negedge clk);
    build_exp(1, 1'b1, 'h0F0, 'h1234, 1'b0);
    check_frames("R11 busy request");
    chk(done_cnt == 1, "R11 only one completion", done_cnt, 1);
    chk(cs == 1'b0 && req_ready == 1'b1, "R11 idle afterwards", {cs, req_ready}, 2'b01);

    // R9: device stays busy past the poll limit
    busy_len = 5000;
    clear_obs();
    send(2, 1'b1, 'h155, 0, 0, 1'b1);
    wait_done();
    chk(to_seen == 1, "R9 timeout flagged", to_seen, 1);
    build_exp(2, 1'b1, 'h155, 0, 1'b0);
    check_frames("R9 no disable after timeout");
    chk(npoll == 1, "R9 single poll period", npoll, 1);
    busy_len = 300;
    repeat (6000) @(negedge clk);

    // R2 / R7 timing minima (13 clocks at 50 MHz for 250 ns)
    chk(min_hi >= PH, "R2 sk high time", min_hi, PH);
    chk(min_lo >= PH, "R2 sk low time", min_lo, PH);
    chk(min_cl >= PH, "R7 cs low gap", min_cl, PH);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule